// File: doc/BRIEF.md
# Endpoint DMA Transfer Termination Controller

This block runs the slave side of a DMA handshake between a host DMA controller and one bulk endpoint buffer of a USB peripheral. Software starts a transfer with a one-cycle start pulse. The start pulse loads a byte down-counter from a 16-bit count setting. While the transfer runs, the block raises a request to the host DMA controller whenever the buffer can take part. The buffer can take part when it holds data for an OUT transfer or has room for an IN transfer. Each accepted data strobe is counted and passed to the buffer as a one-cycle byte pulse.

A transfer stops on the first of four causes:
- the external end-of-transfer input,
- the byte counter running out, if counting is enabled,
- a short packet arriving on an OUT transfer, if short-packet stop is enabled,
- a software stop pulse.

On stopping, the block clears its own running flag. It records the cause in a one-hot status field, which holds until the next start. It also tells the buffer how to finish. An OUT transfer gets a flush of the active buffer; the inactive half of a double buffer is left alone. An IN transfer gets a commit, so that a partial packet goes out at the next IN token.

Data strobes come either from the acknowledge line alone, or from the read strobe (OUT) or the write strobe (IN) qualified by the acknowledge line. All three strobe lines are asynchronous. Each passes through a two-flop synchronizer before its rising edge is detected. The end-of-transfer input, the short-packet flag, the buffer-ready flag and all configuration inputs are synchronous to the clock.

No data moves through this block, so it has no valid/ready stream. The byte pulse carries no back-pressure. The buffer controls the pace only through its ready flag, which gates the request.

Top module: `dma_term_ctrl`

## Requirements
- R1: After reset, dma_req, xfer_active, byte_strobe, flush_req and commit_req are 0 and end_cause is 4'b0000.
- R2: A sw_start pulse while idle sets xfer_active from the next cycle, clears end_cause to 0 and loads the byte counter from cfg_byte_count. A sw_start pulse while active has no effect.
- R3: dma_req is 1 exactly when xfer_active is 1, buf_ready is 1 and no stop cause is present in that cycle. It drops in the same cycle a stop is detected.
- R4: With cfg_ack_only=0, one byte is counted per rising edge of rd_strobe (cfg_dir_in=0) or of wr_strobe (cfg_dir_in=1) while dma_ack is 1. The strobe of the other direction, and any strobe while dma_ack is 0, count nothing.
- R5: With cfg_ack_only=1, one byte is counted per rising edge of dma_ack, and rd_strobe and wr_strobe are ignored.
- R6: With cfg_count_en=1, the byte that brings the counter to its programmed total ends the transfer with end_cause bit 1 (4'b0010).
- R7: eot_in=1 while active ends the transfer on the next clock edge with end_cause bit 0 (4'b0001).
- R8: short_rx=1 while active ends the transfer with end_cause bit 2 (4'b0100) only when cfg_short_en=1 and cfg_dir_in=0. Otherwise it is ignored.
- R9: sw_stop=1 while active ends the transfer with end_cause bit 3 (4'b1000).
- R10: One cycle after the stop is detected, a one-cycle pulse appears on flush_req for OUT (cfg_dir_in=0) or on commit_req for IN (cfg_dir_in=1). Only one of the two pulses appears, and only once per transfer.
- R11: If causes coincide, only one end_cause bit is set, chosen by priority eot_in > count > short_rx > sw_stop. end_cause holds until the next start.
- R12: A cfg_byte_count of 0 means 65536 bytes.
- R13: With cfg_count_en=0, the transfer does not end however many bytes are counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_start | input | 1 | Software start pulse |
| sw_stop | input | 1 | Software stop pulse |
| cfg_count_en | input | 1 | Enable stop on byte count |
| cfg_short_en | input | 1 | Enable stop on short OUT packet |
| cfg_ack_only | input | 1 | 1: acknowledge line alone is the data strobe |
| cfg_dir_in | input | 1 | 1: IN (write to buffer), 0: OUT (read from buffer) |
| cfg_byte_count | input | 16 | Bytes to transfer, 0 means 65536 |
| buf_ready | input | 1 | Buffer has data (OUT) or room (IN) |
| short_rx | input | 1 | Short packet received on the endpoint |
| eot_in | input | 1 | External end-of-transfer |
| dma_ack | input | 1 | DMA acknowledge, asynchronous |
| rd_strobe | input | 1 | Read strobe, asynchronous |
| wr_strobe | input | 1 | Write strobe, asynchronous |
| dma_req | output | 1 | DMA request to the host controller |
| xfer_active | output | 1 | Transfer running |
| byte_strobe | output | 1 | One-cycle pulse per accepted byte |
| flush_req | output | 1 | Flush active buffer (OUT stop) |
| commit_req | output | 1 | Commit partial packet (IN stop) |
| end_cause | output | 4 | One-hot stop cause: bit0 eot, bit1 count, bit2 short, bit3 software |

## Verification
The case hardest to reach from the ports is a zero count setting standing for 65536 bytes. Only a full 16-bit run of strobes shows the counter end at the right byte rather than too early or never. The bench drives the acknowledge line in acknowledge-only mode with one edge every two clocks. It checks that the transfer is still running after 65535 bytes and ends on the next byte. Coinciding causes are reached by raising the external end-of-transfer and the software stop in the same cycle, which shows the priority in the cause field.

// File: rtl/dmat_pkg.sv
package dmat_pkg;
  localparam int CAUSE_W = 4;
  // bit positions of the one-hot stop cause
  localparam int C_EOT   = 0;
  localparam int C_COUNT = 1;
  localparam int C_SHORT = 2;
  localparam int C_SOFT  = 3;
  typedef logic [CAUSE_W-1:0] cause_t;
endpackage

// File: rtl/dmat_strobe_sel.sv
module dmat_strobe_sel #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_only,
  input  logic dir_in,
  input  logic ack_raw,
  input  logic rd_raw,
  input  logic wr_raw,
  output logic byte_edge
);
  localparam int LAST = SYNC_STAGES - 1;

  // lane 0 ack, lane 1 read, lane 2 write
  logic [2:0] chain [SYNC_STAGES];
  logic       src, src_q;
  logic       ack_s, rd_s, wr_s;

  always_ff @(posedge clk) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= {wr_raw, rd_raw, ack_raw};
  end

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rst_n) chain[g] <= '0;
      else        chain[g] <= chain[g-1];
    end
  end

  assign ack_s = chain[LAST][0];
  assign rd_s  = chain[LAST][1];
  assign wr_s  = chain[LAST][2];

  always_comb begin
    if (ack_only) src = ack_s;
    else          src = ack_s & (dir_in ? wr_s : rd_s);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) src_q <= 1'b0;
    else        src_q <= src;
  end

  assign byte_edge = src & ~src_q;

  // R4
  single_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_edge |=> !byte_edge);
endmodule

// File: rtl/dmat_counter.sv
module dmat_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             last
);
  localparam int FULL_W = CNT_W + 1;
  localparam logic [FULL_W-1:0] FULL_CNT = FULL_W'(1) << CNT_W;

  logic [FULL_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= (load_val == '0) ? FULL_CNT : {1'b0, load_val};
    else if (dec)  cnt <= cnt - FULL_W'(1);
  end

  assign last = (cnt == FULL_W'(1));
endmodule

// File: rtl/dmat_term.sv
module dmat_term
  import dmat_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   dir_in,
  input  logic   eot_hit,
  input  logic   cnt_hit,
  input  logic   short_hit,
  input  logic   soft_hit,
  output logic   active,
  output logic   stop_now,
  output cause_t cause,
  output logic   flush,
  output logic   commit
);
  cause_t pick;

  always_comb begin
    pick = '0;
    if      (eot_hit)   pick[C_EOT]   = 1'b1;
    else if (cnt_hit)   pick[C_COUNT] = 1'b1;
    else if (short_hit) pick[C_SHORT] = 1'b1;
    else if (soft_hit)  pick[C_SOFT]  = 1'b1;
  end

  assign stop_now = active & (|pick);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cause  <= '0;
      flush  <= 1'b0;
      commit <= 1'b0;
    end else begin
      flush  <= stop_now & ~dir_in;
      commit <= stop_now & dir_in;
      if (stop_now) begin
        active <= 1'b0;
        cause  <= pick;
      end else if (start && !active) begin
        active <= 1'b1;
        cause  <= '0;
      end
    end
  end

  // R11
  cause_hot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cause));
  // R2
  cause_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> cause == '0);
  // R10
  end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush || commit) |-> (!active && $past(active)));
  // R10
  one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(flush && commit));
endmodule

// File: rtl/dma_term_ctrl.sv
module dma_term_ctrl
  import dmat_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_start,
  input  logic             sw_stop,
  input  logic             cfg_count_en,
  input  logic             cfg_short_en,
  input  logic             cfg_ack_only,
  input  logic             cfg_dir_in,
  input  logic [CNT_W-1:0] cfg_byte_count,
  input  logic             buf_ready,
  input  logic             short_rx,
  input  logic             eot_in,
  input  logic             dma_ack,
  input  logic             rd_strobe,
  input  logic             wr_strobe,
  output logic             dma_req,
  output logic             xfer_active,
  output logic             byte_strobe,
  output logic             flush_req,
  output logic             commit_req,
  output logic [CAUSE_W-1:0] end_cause
);
  logic byte_edge, cnt_last, stop_now, cnt_hit, short_hit, load;
  cause_t cause;

  dmat_strobe_sel #(.SYNC_STAGES(SYNC_STAGES)) u_sel (
    .clk(clk), .rst_n(rst_n), .ack_only(cfg_ack_only), .dir_in(cfg_dir_in),
    .ack_raw(dma_ack), .rd_raw(rd_strobe), .wr_raw(wr_strobe),
    .byte_edge(byte_edge));

  assign byte_strobe = byte_edge & xfer_active;
  assign load        = sw_start & ~xfer_active;

  dmat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(cfg_byte_count),
    .dec(byte_strobe), .last(cnt_last));

  assign cnt_hit   = byte_strobe & cnt_last & cfg_count_en;
  assign short_hit = short_rx & cfg_short_en & ~cfg_dir_in;

  dmat_term u_term (
    .clk(clk), .rst_n(rst_n), .start(sw_start), .dir_in(cfg_dir_in),
    .eot_hit(eot_in), .cnt_hit(cnt_hit), .short_hit(short_hit),
    .soft_hit(sw_stop), .active(xfer_active), .stop_now(stop_now),
    .cause(cause), .flush(flush_req), .commit(commit_req));

  assign end_cause = cause;
  assign dma_req   = xfer_active & buf_ready & ~stop_now;

  // R7
  eot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eot_in && xfer_active) |=> (!xfer_active && end_cause == 4'b0001));
endmodule

// File: tb/dma_term_ctrl_test.sv
module dma_term_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic sw_start = 0, sw_stop = 0, cfg_count_en = 0, cfg_short_en = 0;
  logic cfg_ack_only = 0, cfg_dir_in = 0, buf_ready = 1, short_rx = 0, eot_in = 0;
  logic dma_ack = 0, rd_strobe = 0, wr_strobe = 0;
  logic [15:0] cfg_byte_count = 0;
  logic dma_req, xfer_active, byte_strobe, flush_req, commit_req;
  logic [3:0] end_cause;

  int checks = 0, errors = 0, bytes_seen = 0, cycles = 0;
  bit done = 0;
  logic [4:0] exp_q[$];

  always #2.5 clk = ~clk;

  dma_term_ctrl uut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // monitor: byte tally and end-action scoreboard
  always @(negedge clk) begin
    cycles++;
    if (rst_n && byte_strobe) bytes_seen++;
    if (rst_n && (flush_req || commit_req)) begin
      if (exp_q.size() == 0) chk(0, "R10 unexpected end", {flush_req, end_cause}, 0);
      else begin
        logic [4:0] e;
        e = exp_q.pop_front();
        chk({flush_req, end_cause} == e && !(flush_req && commit_req),
            "R10/R11 end action", {flush_req, end_cause}, e);
      end
    end
    if (cycles > 195000) begin
      chk(0, "watchdog", cycles, 195000);
      finish_run();
    end
  end

  task automatic expect_end(input bit is_flush, input logic [3:0] c);
    exp_q.push_back({is_flush, c});
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start(input logic [15:0] n);
    cfg_byte_count = n;
    sw_start = 1; wait_n(1); sw_start = 0;
  endtask

  task automatic pulse_rd();
    rd_strobe = 1; wait_n(3); rd_strobe = 0; wait_n(3);
  endtask

  task automatic pulse_wr();
    wr_strobe = 1; wait_n(3); wr_strobe = 0; wait_n(3);
  endtask

  task automatic pulse_ack();
    dma_ack = 1; wait_n(1); dma_ack = 0; wait_n(1);
  endtask

  task automatic drained(input string req);
    wait_n(4);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  initial begin
    wait_n(3);
    rst_n = 1;
    wait_n(1);
    // R1 reset state
    chk(!dma_req && !xfer_active && !byte_strobe && !flush_req && !commit_req && end_cause == 0,
        "R1 reset", {dma_req, xfer_active, flush_req, commit_req, end_cause}, 0);

    // OUT, qualified strobes, count 3
    cfg_count_en = 1; cfg_dir_in = 0; cfg_ack_only = 0;
    start(3);
    chk(xfer_active && end_cause == 0, "R2 start", {xfer_active, end_cause}, 5'h10);
    chk(dma_req, "R3 request with buffer ready", dma_req, 1);
    buf_ready = 0; wait_n(1);
    chk(!dma_req, "R3 request gated by buffer", dma_req, 0);
    buf_ready = 1;
    bytes_seen = 0;
    dma_ack = 1; pulse_wr();
    dma_ack = 0; pulse_rd();
    chk(bytes_seen == 0, "R4 wrong strobe ignored", bytes_seen, 0);
    sw_start = 1; wait_n(1); sw_start = 0;
    chk(xfer_active && end_cause == 0, "R2 start while active ignored", xfer_active, 1);
    dma_ack = 1; pulse_rd(); pulse_rd();
    chk(bytes_seen == 2 && xfer_active, "R4 two bytes counted", bytes_seen, 2);
    expect_end(1, 4'b0010);
    pulse_rd();
    dma_ack = 0;
    chk(bytes_seen == 3 && !xfer_active && end_cause == 4'b0010, "R6 count stop",
        {bytes_seen[3:0], end_cause}, 8'h32);
    drained("R10 flush on OUT");

    // IN, ack-only mode, count 2, read/write ignored
    cfg_dir_in = 1; cfg_ack_only = 1;
    start(2);
    chk(end_cause == 0, "R2 cause cleared on start", end_cause, 0);
    bytes_seen = 0;
    pulse_wr(); pulse_rd();
    chk(bytes_seen == 0, "R5 rd/wr ignored", bytes_seen, 0);
    pulse_ack();
    wait_n(3);
    chk(bytes_seen == 1 && xfer_active, "R5 ack edge counted", bytes_seen, 1);
    expect_end(0, 4'b0010);
    pulse_ack();
    wait_n(3);
    chk(!xfer_active && end_cause == 4'b0010, "R6 IN count stop", end_cause, 2);
    drained("R10 commit on IN");

    // external end-of-transfer, request drops in same cycle
    start(100);
    expect_end(0, 4'b0001);
    eot_in = 1;
    #1;
    chk(!dma_req && xfer_active, "R3 request drops with stop", {dma_req, xfer_active}, 1);
    wait_n(1); eot_in = 0;
    chk(!xfer_active && end_cause == 4'b0001, "R7 external stop", end_cause, 1);
    drained("R7 commit after external stop");

    // short packet: ignored on IN, ignored when disabled, stops OUT
    start(100);
    cfg_short_en = 1;
    short_rx = 1; wait_n(1); short_rx = 0;
    chk(xfer_active, "R8 short ignored on IN", xfer_active, 1);
    cfg_dir_in = 0; cfg_short_en = 0;
    short_rx = 1; wait_n(1); short_rx = 0;
    chk(xfer_active, "R8 short ignored when disabled", xfer_active, 1);
    cfg_short_en = 1;
    expect_end(1, 4'b0100);
    short_rx = 1; wait_n(1); short_rx = 0;
    chk(!xfer_active && end_cause == 4'b0100, "R8 short stop", end_cause, 4);
    drained("R8 flush after short");
    cfg_short_en = 0;

    // software stop, and priority with coinciding causes
    start(100);
    expect_end(1, 4'b1000);
    sw_stop = 1; wait_n(1); sw_stop = 0;
    chk(end_cause == 4'b1000, "R9 software stop", end_cause, 8);
    drained("R9 flush after software stop");
    start(100);
    expect_end(1, 4'b0001);
    sw_stop = 1; eot_in = 1; wait_n(1); sw_stop = 0; eot_in = 0;
    chk(end_cause == 4'b0001, "R11 priority eot over software", end_cause, 1);
    wait_n(5);
    chk(end_cause == 4'b0001, "R11 cause held", end_cause, 1);
    drained("R11 single end action");

    // count disabled: no stop after many bytes
    cfg_count_en = 0; cfg_ack_only = 1; cfg_dir_in = 1;
    start(1);
    bytes_seen = 0;
    for (int i = 0; i < 4; i++) pulse_ack();
    wait_n(3);
    chk(xfer_active && bytes_seen == 4, "R13 no count stop", {xfer_active, bytes_seen[3:0]}, 5'h14);
    expect_end(0, 4'b1000);
    sw_stop = 1; wait_n(1); sw_stop = 0;
    drained("R13 end by software");

    // zero setting means 65536 bytes
    cfg_count_en = 1;
    start(0);
    bytes_seen = 0;
    for (int i = 0; i < 65535; i++) pulse_ack();
    wait_n(3);
    chk(xfer_active && bytes_seen == 65535, "R12 still active at 65535", bytes_seen, 65535);
    expect_end(0, 4'b0010);
    pulse_ack();
    wait_n(3);
    chk(!xfer_active && bytes_seen == 65536 && end_cause == 4'b0010, "R12 stop at 65536",
        bytes_seen, 65536);
    drained("R12 commit after full count");

    finish_run();
  end
endmodule